// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of general-purpose pins that a processor controls through a small memory-mapped register port. The port has an address, write data, a write strobe and combinational read data. Software drives outputs through separate write-one-to-set and write-one-to-clear registers. It picks each pin's direction and reads the pin levels after they have been synchronised to the bank clock.

Each pin can raise an interrupt. Three independent bit-vectors choose the trigger for each pin: one for edge or level, one for single or both edges, and one for polarity. Edge events stay latched in a raw status register until software acknowledges them by writing ones. In level mode the raw bit follows the pin condition instead. A masked view applies a per-pin enable and a per-pin mask. All masked bits are ORed into one interrupt line for the bank, and the handler scans raw status to find the source.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every writable register, raw status, `pin_out`, `pin_is_in` and `irq` are zero.
- R2: Writing to offset 0x10 drives high each output bit written as 1 and leaves the 0 bits unchanged. Reading 0x10 or 0x14 returns the current output data.
- R3: Writing to offset 0x14 drives low each output bit written as 1 and leaves the 0 bits unchanged.
- R4: Offset 0x04 reads the pin levels through a two-flop synchroniser. A pin change made before clock edge k is readable after edge k+1 and not after edge k.
- R5: Offset 0x08 holds the direction, where 1 means input. It reads back and drives `pin_is_in`.
- R6: A 1 in the trigger-method vector (0x34) selects level mode. In that mode the raw status bit follows the synchronised condition one cycle later, and writes to the acknowledge register do not clear it.
- R7: In edge mode, a 1 in the both-edges vector (0x38) detects rising and falling edges, and the polarity bit is then ignored.
- R8: The polarity vector (0x3C) selects a rising edge or high level when 0, and a falling edge or low level when 1.
- R9: An edge event sets its raw status bit (0x24), which stays set until a 1 is written to that bit of the acknowledge register (0x30). Bits written as 0 have no effect.
- R10: When an edge event and an acknowledge for the same bit happen in the same cycle, the bit stays set.
- R11: Masked status (0x28) is raw status AND enable (0x20) AND NOT mask (0x2C).
- R12: `irq` is high exactly when some masked status bit is set.
- R13: Unmapped offsets read as zero. Writes to the input, raw-status and masked-status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data register |
| pin_is_in | output | 32 | Direction, 1 = input |
| irq | output | 1 | Combined bank interrupt |

## Verification
The assertions assume that `addr`, `wr_en` and `wr_data` are stable around each rising edge, and that `pin_in` does not change faster than the synchroniser can capture. They also assume that a trigger configuration is not rewritten in the same cycle an event is judged. The stimulus changes every input just after a clock edge. It holds each pin level for at least three cycles, and it reprograms the trigger vectors only while the pins are quiet. The one deliberate overlap is the acknowledge cycle that is placed on the edge-capture cycle to test the collision rule.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // Byte offsets decoded by the driver software
   localparam int unsigned OFS_INPUT  = 32'h04;
   localparam int unsigned OFS_DIR    = 32'h08;
   localparam int unsigned OFS_SET    = 32'h10;
   localparam int unsigned OFS_CLR    = 32'h14;
   localparam int unsigned OFS_IEN    = 32'h20;
   localparam int unsigned OFS_RAW    = 32'h24;
   localparam int unsigned OFS_MSKD   = 32'h28;
   localparam int unsigned OFS_MASK   = 32'h2C;
   localparam int unsigned OFS_ACK    = 32'h30;
   localparam int unsigned OFS_METHOD = 32'h34;
   localparam int unsigned OFS_BOTH   = 32'h38;
   localparam int unsigned OFS_POL    = 32'h3C;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= '0;
            else if (s == 0) stg[s] <= d;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] s_lvl,     // synchronised pin levels
   input  logic [W-1:0] lvl_mode,  // 1 = level trigger
   input  logic [W-1:0] both,      // 1 = both edges (edge mode)
   input  logic [W-1:0] neg,       // 1 = falling / low
   input  logic [W-1:0] ack,       // write-one-to-clear pulses
   output logic [W-1:0] raw_q
);
   logic [W-1:0] prev_q;
   logic [W-1:0] raw_d;

   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         logic rise, fall, edge_hit, lvl_hit;
         always_comb begin
            rise     = s_lvl[i] & ~prev_q[i];
            fall     = ~s_lvl[i] & prev_q[i];
            if (both[i]) edge_hit = rise | fall;
            else         edge_hit = neg[i] ? fall : rise;
            lvl_hit  = s_lvl[i] ^ neg[i];
            if (lvl_mode[i]) raw_d[i] = lvl_hit;
            else             raw_d[i] = (raw_q[i] & ~ack[i]) | edge_hit;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         raw_q  <= '0;
      end else begin
         prev_q <= s_lvl;
         raw_q  <= raw_d;
      end
   end

   logic [W-1:0] hold_v;
   assign hold_v = ~lvl_mode & raw_q & ~ack;

   // Latched edge status survives until acknowledged
   assert_edge_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_q & $past(hold_v)) == $past(hold_v)));

   // Level mode tracks the synchronised condition one cycle later
   assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((raw_q ^ $past(s_lvl ^ neg)) & $past(lvl_mode)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS        = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [PINS-1:0]   wr_data,
   output logic [PINS-1:0]   rd_data,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_is_in,
   output logic              irq
);
   generate
      if (PINS < 1 || PINS > 32) begin : g_bad_pins
         $error("gpio_irq_bank: PINS must be 1..32");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("gpio_irq_bank: ADDR_W too small for the register map");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_INPUT  = ADDR_W'(OFS_INPUT);
   localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MSKD   = ADDR_W'(OFS_MSKD);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);
   localparam logic [ADDR_W-1:0] A_METHOD = ADDR_W'(OFS_METHOD);
   localparam logic [ADDR_W-1:0] A_BOTH   = ADDR_W'(OFS_BOTH);
   localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFS_POL);

   logic [PINS-1:0] out_q, dir_q, ien_q, mask_q, meth_q, both_q, pol_q;
   logic [PINS-1:0] s_lvl, raw_q, ack_v, masked;

   gpio_sync_chain #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(s_lvl));

   assign ack_v = (wr_en && addr == A_ACK) ? wr_data : '0;

   gpio_trig_detect #(.W(PINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .s_lvl(s_lvl), .lvl_mode(meth_q),
      .both(both_q), .neg(pol_q), .ack(ack_v), .raw_q(raw_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         ien_q  <= '0;
         mask_q <= '0;
         meth_q <= '0;
         both_q <= '0;
         pol_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            A_DIR:    dir_q  <= wr_data;
            A_SET:    out_q  <= out_q | wr_data;
            A_CLR:    out_q  <= out_q & ~wr_data;
            A_IEN:    ien_q  <= wr_data;
            A_MASK:   mask_q <= wr_data;
            A_METHOD: meth_q <= wr_data;
            A_BOTH:   both_q <= wr_data;
            A_POL:    pol_q  <= wr_data;
            default:  ;
         endcase
      end
   end

   assign masked = raw_q & ien_q & ~mask_q;

   always_comb begin
      case (addr)
         A_INPUT:        rd_data = s_lvl;
         A_DIR:          rd_data = dir_q;
         A_SET, A_CLR:   rd_data = out_q;
         A_IEN:          rd_data = ien_q;
         A_RAW:          rd_data = raw_q;
         A_MSKD:         rd_data = masked;
         A_MASK:         rd_data = mask_q;
         A_METHOD:       rd_data = meth_q;
         A_BOTH:         rd_data = both_q;
         A_POL:          rd_data = pol_q;
         default:        rd_data = '0;
      endcase
   end

   assign pin_out   = out_q;
   assign pin_is_in = dir_q;
   assign irq       = |masked;

   // Set register: written ones go high, other bits keep their value
   assert_set_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET) |=> ((pin_out & $past(wr_data)) == $past(wr_data)));
   assert_set_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET) |=> (((pin_out ^ $past(pin_out)) & ~$past(wr_data)) == '0));
   // Clear register: written ones go low
   assert_clr_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CLR) |=> ((pin_out & $past(wr_data)) == '0));
   // No interrupt while every pin is disabled or masked
   assert_irq_noen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);
   assert_irq_allmask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq);
endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_is_in;
   logic        irq;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   gpio_irq_bank dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pin_out(pin_out), .pin_is_in(pin_is_in), .irq(irq));

   // {method, both, polarity, start level, end level, expected raw bit}
   localparam logic [5:0] TRIG_TAB [10] = '{
      6'b000011, 6'b000100, 6'b001101, 6'b001010, 6'b011011,
      6'b010101, 6'b100011, 6'b100100, 6'b101101, 6'b101010 };

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; #1; d = rd_data;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      #500000;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rd(8'h08, v); chk("R1 dir", v, 0);
      rd(8'h10, v); chk("R1 out", v, 0);
      rd(8'h24, v); chk("R1 raw", v, 0);
      chk("R1 pins", {pin_out | pin_is_in}, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      // trigger table on pin 0
      for (int k = 0; k < 10; k++) begin
         logic [5:0] e;
         string tag;
         e = TRIG_TAB[k];
         tag = e[5] ? "R6 level" : (e[4] ? "R7 both" : "R8 polarity");
         wr(8'h34, {31'b0, e[5]});
         wr(8'h38, {31'b0, e[4]});
         wr(8'h3C, {31'b0, e[3]});
         pin_in[0] = e[2];
         tick(4);
         wr(8'h30, 32'h1);
         pin_in[0] = e[1];
         tick(3);
         rd(8'h24, v);
         chk(tag, {31'b0, v[0]}, {31'b0, e[0]});
      end
      wr(8'h34, 0); wr(8'h38, 0); wr(8'h3C, 0);
      pin_in[0] = 1'b0; tick(4); wr(8'h30, 32'hFFFF_FFFF);

      // R2 / R3 output set and clear
      wr(8'h10, 32'hF0F0_0001); chk("R2 set", pin_out, 32'hF0F0_0001);
      wr(8'h10, 32'h0000_0100); chk("R2 keep", pin_out, 32'hF0F0_0101);
      rd(8'h14, v);             chk("R2 readback", v, 32'hF0F0_0101);
      wr(8'h14, 32'hF000_0001); chk("R3 clear", pin_out, 32'h00F0_0100);

      // R5 direction
      wr(8'h08, 32'hA5A5_0000);
      rd(8'h08, v); chk("R5 dir read", v, 32'hA5A5_0000);
      chk("R5 dir pins", pin_is_in, 32'hA5A5_0000);

      // R4 synchronised input, R9 latch
      pin_in = 32'h1234_5678;
      tick(1); rd(8'h04, v); chk("R4 not yet", v, 0);
      tick(1); rd(8'h04, v); chk("R4 visible", v, 32'h1234_5678);
      tick(1); rd(8'h24, v); chk("R9 rise latched", v, 32'h1234_5678);
      chk("R12 no enable", {31'b0, irq}, 0);
      pin_in = '0;
      tick(4); rd(8'h24, v); chk("R9 held", v, 32'h1234_5678);
      wr(8'h30, 32'h0000_0078);
      rd(8'h24, v); chk("R9 partial ack", v, 32'h1234_5600);
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h24, v); chk("R9 full ack", v, 0);

      // R13 read-only and unmapped
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h24, v); chk("R13 raw untouched", v, 0);
      rd(8'h00, v); chk("R13 unmapped 00", v, 0);
      rd(8'h40, v); chk("R13 unmapped 40", v, 0);

      // R11 / R12 enable and mask on pin 5
      pin_in[5] = 1'b1; tick(3);
      rd(8'h28, v); chk("R11 masked no en", v, 0);
      wr(8'h20, 32'h20);
      rd(8'h28, v); chk("R11 masked en", v, 32'h20);
      chk("R12 irq on", {31'b0, irq}, 1);
      wr(8'h2C, 32'h20);
      rd(8'h28, v); chk("R11 masked off", v, 0);
      chk("R12 irq masked", {31'b0, irq}, 0);
      wr(8'h2C, 0);
      chk("R12 irq unmasked", {31'b0, irq}, 1);
      wr(8'h30, 32'h20);
      chk("R12 irq acked", {31'b0, irq}, 0);
      pin_in[5] = 1'b0; tick(3);

      // R10 event vs acknowledge in the same cycle, pin 6 both edges
      wr(8'h38, 32'h40);
      pin_in[6] = 1'b1; tick(3);
      rd(8'h24, v); chk("R7 both rise", v & 32'h40, 32'h40);
      pin_in[6] = 1'b0; tick(2);
      wr(8'h30, 32'h40);
      rd(8'h24, v); chk("R10 event wins", v & 32'h40, 32'h40);
      wr(8'h30, 32'h40);
      rd(8'h24, v); chk("R9 ack after", v & 32'h40, 0);

      // R6 level mode ignores acknowledge and follows the pin
      wr(8'h34, 32'h80);
      pin_in[7] = 1'b1; tick(3);
      wr(8'h30, 32'h80);
      rd(8'h24, v); chk("R6 ack ignored", v & 32'h80, 32'h80);
      pin_in[7] = 1'b0; tick(3);
      rd(8'h24, v); chk("R6 follows low", v & 32'h80, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule